// File: doc/BRIEF.md
# Multicast Port-Flush Table Sweeper

This block is a background engine that sits beside a forwarding-table RAM. On a start command it visits every table index in order and withdraws a chosen set of egress ports from the multicast entries it finds. The caller supplies a port mask and a VLAN selector: a 12-bit VLAN ID, or a wildcard flag that makes the sweep ignore VLAN IDs. An entry that loses its last port is released by rewriting its type code to free.

Each entry costs two cycles. In the first the engine issues a read to the RAM. In the second the RAM returns the data, a combinational evaluator decides whether the entry qualifies, and the engine writes the result back at the same index if anything changed. The RAM port carries no handshake: a read returns its data exactly one cycle later, and neither side can apply back-pressure. Control is a plain start pulse, a busy level and a one-cycle done pulse.

Entry layout, with the entry `66+PORTS` bits wide:
- [47:0] MAC address; bit 40 is the multicast flag.
- [59:48] VLAN ID.
- [61:60] type code: 0 free, 1 address, 2 VLAN, 3 VLAN+address.
- [65] super flag.
- [66 +: PORTS] port mask.

Top module: `mcast_flush_sweeper`

## Requirements
- R1: A start pulse seen while idle begins a sweep. busy_o rises on the next cycle and stays high for exactly 2*DEPTH cycles. Indices 0 to DEPTH-1 are visited in ascending order, each as one read cycle followed by one evaluate cycle. No RAM read or write is issued while the block is idle.
- R2: done_o is high for exactly one cycle. That cycle follows the evaluate cycle of the last index, and busy_o is low in it.
- R3: The port mask, VLAN ID and wildcard flag are captured when a start is accepted. A start pulse that arrives while busy is ignored, along with the inputs that come with it.
- R4: Only entries whose type code at bits 61:60 is 1 (address) or 3 (VLAN+address) may be modified. All other type codes are left unchanged.
- R5: When the wildcard flag is low, entries whose VLAN ID at bits 59:48 differs from the captured ID are left unchanged. When the flag is high, the VLAN ID is ignored.
- R6: An entry is modified only if its multicast bit 40 is 1 and its super bit 65 is 0.
- R7: An entry whose address bits 47:0 are all ones (broadcast) is left unchanged.
- R8: An entry whose port mask at bits 66 upward has no port in common with the requested mask is left unchanged.
- R9: For a qualifying entry whose reduced mask (old mask AND NOT requested mask) is nonzero, the reduced mask is written back and every other bit is kept.
- R10: For a qualifying entry whose reduced mask is zero, bits 61:60 are written as 0 (free) and every other bit, including the old mask, is kept.
- R11: The RAM read has a latency of one cycle. Any write goes to the index that was read in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse; acted on only when idle |
| port_mask_i | input | PORTS | Ports to remove from multicast entries |
| vid_i | input | 12 | VLAN ID to match |
| all_vlan_i | input | 1 | 1: ignore the VLAN ID and process every VLAN |
| busy_o | output | 1 | High while a sweep is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a sweep |
| mem_addr_o | output | $clog2(DEPTH) | Table index for the read or write |
| mem_rd_en_o | output | 1 | Read strobe; data is returned the next cycle |
| mem_rdata_i | input | 66+PORTS | Entry read from the table |
| mem_wr_en_o | output | 1 | Write strobe |
| mem_wdata_o | output | 66+PORTS | Entry written back to the table |

## Verification
The sweep is repeated once for every possible requested port mask on a 4-port, 16-entry table. The table is filled arithmetically so that every skip rule occurs at several indices: wrong type code, VLAN mismatch, cleared multicast bit, super bit, broadcast address and a disjoint mask. Alternating the VLAN ID and the wildcard flag separates the VLAN-match rule from the wildcard path. Sweeping the requested mask over every value separates the partial-clear case from the free-the-entry case for the same stored mask. One further sweep receives a second start, carrying different inputs, in the middle of the run; its outcome is compared against the first start's parameters to show that the second start was ignored.

// File: rtl/msw_pkg.sv
package msw_pkg;
  localparam int ADDR_LSB  = 0;
  localparam int ADDR_W    = 48;
  localparam int MCAST_BIT = 40;
  localparam int VID_LSB   = 48;
  localparam int VID_W     = 12;
  localparam int TYPE_LSB  = 60;
  localparam int SUPER_BIT = 65;
  localparam int MASK_LSB  = 66;

  typedef enum logic [1:0] {
    KIND_FREE  = 2'd0,
    KIND_ADDR  = 2'd1,
    KIND_VLAN  = 2'd2,
    KIND_VADDR = 2'd3
  } entry_kind_e;

  typedef enum logic [1:0] {
    W_IDLE = 2'd0,
    W_READ = 2'd1,
    W_EVAL = 2'd2
  } walk_state_e;
endpackage

// File: rtl/msw_entry_eval.sv
module msw_entry_eval
  import msw_pkg::*;
#(
  parameter int PORTS = 4,
  localparam int ENTRY_W = MASK_LSB + PORTS
) (
  input  logic [ENTRY_W-1:0] entry_i,
  input  logic [PORTS-1:0]   req_mask_i,
  input  logic [VID_W-1:0]   vid_i,
  input  logic               all_vlan_i,
  output logic               modify_o,
  output logic [ENTRY_W-1:0] entry_o
);
  entry_kind_e      kind;
  logic             kind_ok, vid_ok, mc_ok, bcast, hit;
  logic [PORTS-1:0] old_mask, new_mask;

  always_comb begin
    kind     = entry_kind_e'(entry_i[TYPE_LSB +: 2]);
    kind_ok  = (kind == KIND_ADDR) || (kind == KIND_VADDR);
    vid_ok   = all_vlan_i || (entry_i[VID_LSB +: VID_W] == vid_i);
    mc_ok    = entry_i[MCAST_BIT] && !entry_i[SUPER_BIT];
    bcast    = &entry_i[ADDR_LSB +: ADDR_W];
    old_mask = entry_i[MASK_LSB +: PORTS];
    hit      = |(old_mask & req_mask_i);
    new_mask = old_mask & ~req_mask_i;
    modify_o = kind_ok && vid_ok && mc_ok && !bcast && hit;
    entry_o  = entry_i;
    if (new_mask == '0) entry_o[TYPE_LSB +: 2] = KIND_FREE;
    else                entry_o[MASK_LSB +: PORTS] = new_mask;
  end
endmodule

// File: rtl/msw_walker.sv
module msw_walker
  import msw_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             accept_o,
  output logic             read_o,
  output logic             eval_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [IDX_W-1:0] idx_o
);
  walk_state_e      state;
  logic [IDX_W-1:0] idx;
  logic             done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= W_IDLE;
      idx    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        W_IDLE: if (start_i) begin
          state <= W_READ;
          idx   <= '0;
        end
        W_READ: state <= W_EVAL;
        W_EVAL: begin
          if (idx == LAST) begin
            state  <= W_IDLE;
            done_q <= 1'b1;
          end else begin
            idx   <= idx + 1'b1;
            state <= W_READ;
          end
        end
        default: state <= W_IDLE;
      endcase
    end
  end

  assign accept_o = (state == W_IDLE) && start_i;
  assign read_o   = (state == W_READ);
  assign eval_o   = (state == W_EVAL);
  assign busy_o   = (state != W_IDLE);
  assign done_o   = done_q;
  assign idx_o    = idx;
endmodule

// File: rtl/mcast_flush_sweeper.sv
module mcast_flush_sweeper
  import msw_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PORTS = 4,
  localparam int ENTRY_W = MASK_LSB + PORTS,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [PORTS-1:0]   port_mask_i,
  input  logic [VID_W-1:0]   vid_i,
  input  logic               all_vlan_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [IDX_W-1:0]   mem_addr_o,
  output logic               mem_rd_en_o,
  input  logic [ENTRY_W-1:0] mem_rdata_i,
  output logic               mem_wr_en_o,
  output logic [ENTRY_W-1:0] mem_wdata_o
);
  logic             accept, eval, modify;
  logic [PORTS-1:0] req_mask_q;
  logic [VID_W-1:0] vid_q;
  logic             all_q;

  msw_walker #(.DEPTH(DEPTH)) u_walker (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .accept_o (accept),
    .read_o   (mem_rd_en_o),
    .eval_o   (eval),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .idx_o    (mem_addr_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_mask_q <= '0;
      vid_q      <= '0;
      all_q      <= 1'b0;
    end else if (accept) begin
      req_mask_q <= port_mask_i;
      vid_q      <= vid_i;
      all_q      <= all_vlan_i;
    end
  end

  msw_entry_eval #(.PORTS(PORTS)) u_eval (
    .entry_i    (mem_rdata_i),
    .req_mask_i (req_mask_q),
    .vid_i      (vid_q),
    .all_vlan_i (all_q),
    .modify_o   (modify),
    .entry_o    (mem_wdata_o)
  );

  assign mem_wr_en_o = eval && modify;
endmodule

// File: rtl/msw_checker.sv
module msw_checker
  import msw_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PORTS = 4,
  localparam int ENTRY_W = MASK_LSB + PORTS,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy_o,
  input logic               done_o,
  input logic [IDX_W-1:0]   mem_addr_o,
  input logic               mem_rd_en_o,
  input logic [ENTRY_W-1:0] mem_rdata_i,
  input logic               mem_wr_en_o,
  input logic [ENTRY_W-1:0] mem_wdata_o
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mem_rd_en_o && !mem_wr_en_o));

  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_not_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_busy_ends_with_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  assert_write_follows_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en_o |-> ($past(mem_rd_en_o) && mem_addr_o == $past(mem_addr_o)));

  assert_write_kind_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en_o |-> (mem_rdata_i[TYPE_LSB +: 2] == KIND_ADDR || mem_rdata_i[TYPE_LSB +: 2] == KIND_VADDR));

  assert_write_multicast_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en_o |-> (mem_rdata_i[MCAST_BIT] && !mem_rdata_i[SUPER_BIT]));

  assert_bcast_untouched_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en_o |-> !(&mem_rdata_i[ADDR_LSB +: ADDR_W]));

  assert_mask_never_grows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en_o |-> ((mem_wdata_o[MASK_LSB +: PORTS] & ~mem_rdata_i[MASK_LSB +: PORTS]) == '0));
endmodule

bind mcast_flush_sweeper msw_checker #(.DEPTH(DEPTH), .PORTS(PORTS)) u_msw_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .mem_addr_o  (mem_addr_o),
  .mem_rd_en_o (mem_rd_en_o),
  .mem_rdata_i (mem_rdata_i),
  .mem_wr_en_o (mem_wr_en_o),
  .mem_wdata_o (mem_wdata_o)
);

// File: tb/mcast_flush_sweeper_bench.sv
module mcast_flush_sweeper_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int PORTS = 4;
  localparam int EW = 66 + PORTS;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [PORTS-1:0] pmask = '0;
  logic [11:0] vid = '0;
  logic allv = 1'b0;
  logic busy, done, rd_en, wr_en;
  logic [AW-1:0] addr;
  logic [EW-1:0] rdata, wdata;

  logic [EW-1:0] mem [DEPTH];
  logic [EW-1:0] gold [DEPTH];
  logic ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [EW-1:0] ld_data = '0;

  int n_tests = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcast_flush_sweeper #(.DEPTH(DEPTH), .PORTS(PORTS)) u_mcast_flush_sweeper (
    .clk(clk), .rst_n(rst_n), .start_i(start), .port_mask_i(pmask),
    .vid_i(vid), .all_vlan_i(allv), .busy_o(busy), .done_o(done),
    .mem_addr_o(addr), .mem_rd_en_o(rd_en), .mem_rdata_i(rdata),
    .mem_wr_en_o(wr_en), .mem_wdata_o(wdata)
  );

  // RAM model: one-cycle read latency (R11)
  always @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (wr_en) mem[addr] <= wdata;
    if (rd_en) rdata <= mem[addr];
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [EW-1:0] act, input logic [EW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [EW-1:0] make_entry(int i, int s);
    logic [EW-1:0] e = '0;
    e[47:0]  = 48'h0100_5E00_0000 + 48'(i * 257 + s);
    if (i % 7 == 3) e[47:0] = '1;
    e[40]    = ((i + s) % 4 != 1);
    e[59:48] = (i % 3 == 0) ? 12'h0A5 : 12'h0A6;
    e[61:60] = 2'((i + s) % 4);
    e[64]    = i[0];
    e[65]    = (i % 5 == 4);
    e[66 +: PORTS] = PORTS'((i * 3 + s) % 16);
    return e;
  endfunction

  function automatic logic [EW-1:0] expect_entry(logic [EW-1:0] e, logic [PORTS-1:0] rq,
                                                 logic [11:0] v, bit all, output string tag);
    logic [EW-1:0] r = e;
    logic [PORTS-1:0] m = e[66 +: PORTS];
    if (!(e[61:60] == 2'd1 || e[61:60] == 2'd3)) tag = "R4";
    else if (!all && e[59:48] != v) tag = "R5";
    else if (!e[40] || e[65]) tag = "R6";
    else if (e[47:0] == 48'hFFFF_FFFF_FFFF) tag = "R7";
    else if ((m & rq) == '0) tag = "R8";
    else if ((m & ~rq) != '0) begin
      tag = "R9";
      r[66 +: PORTS] = m & ~rq;
    end else begin
      tag = "R10";
      r[61:60] = 2'd0;
    end
    return r;
  endfunction

  task automatic load_table(int s, logic [PORTS-1:0] rq, logic [11:0] v, bit all);
    string t;
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_addr = AW'(i); ld_data = make_entry(i, s);
      gold[i] = expect_entry(ld_data, rq, v, all, t);
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // Run a sweep; optionally inject a second start mid-sweep (R3)
  task automatic run_sweep(logic [PORTS-1:0] rq, logic [11:0] v, bit all, bit inject);
    int bcnt = 0;
    int guard = 0;
    @(negedge clk);
    start = 1'b1; pmask = rq; vid = v; allv = all;
    @(negedge clk);
    start = 1'b0;
    while (!done && guard < 4 * DEPTH + 8) begin
      if (busy) bcnt++;
      guard++;
      if (inject && guard == 5) begin
        start = 1'b1; pmask = ~rq; vid = v ^ 12'h003; allv = ~all;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check(bcnt == 2 * DEPTH, "R1", "busy cycle count", EW'(bcnt), EW'(2 * DEPTH));
    check(done && !busy, "R2", "done high with busy low", EW'({done, busy}), EW'(2'b10));
    @(negedge clk);
    check(!done && !busy, "R2", "done one cycle wide", EW'({done, busy}), EW'(2'b00));
  endtask

  task automatic compare_table(string ctx);
    string t;
    logic [EW-1:0] dummy;
    for (int i = 0; i < DEPTH; i++) begin
      dummy = expect_entry(make_entry(i, 0), '0, '0, 1'b1, t);
      check(mem[i] === gold[i], ctx, $sformatf("entry %0d (R11 read/write path)", i), mem[i], gold[i]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !rd_en && !wr_en, "R1", "reset state",
          EW'({busy, done, rd_en, wr_en}), '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done, "R1", "idle after reset", EW'({busy, done}), '0);

    // Every requested mask, alternating VLAN mode (R4 R5 R6 R7 R8 R9 R10)
    for (int s = 0; s < 16; s++) begin
      logic [PORTS-1:0] rq = PORTS'(s);
      logic [11:0] v = (s % 4 == 2) ? 12'h0A6 : 12'h0A5;
      bit all = s[0];
      load_table(s, rq, v, all);
      run_sweep(rq, v, all, 1'b0);
      for (int i = 0; i < DEPTH; i++) begin
        string t;
        logic [EW-1:0] ex;
        ex = expect_entry(make_entry(i, s), rq, v, all, t);
        check(mem[i] === ex, t, $sformatf("sweep %0d entry %0d", s, i), mem[i], ex);
      end
    end

    // Start while busy must be ignored (R3)
    load_table(5, 4'b0110, 12'h0A5, 1'b0);
    run_sweep(4'b0110, 12'h0A5, 1'b0, 1'b1);
    compare_table("R3");

    // Back-to-back: second sweep over result of the first, full mask, wildcard (R10)
    for (int i = 0; i < DEPTH; i++) begin
      string t;
      gold[i] = expect_entry(mem[i], 4'hF, 12'h000, 1'b1, t);
    end
    run_sweep(4'hF, 12'h000, 1'b1, 1'b0);
    compare_table("R10");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule